// File: doc/BRIEF.md
# Polyphase Decimate-by-25 FIR Filter

This block lowers the sample rate of a stream of signed 16-bit samples by a factor of 25 and low-pass filters it on the way. The filter is a 75-tap prototype held as a parameter. It is split into 25 branch filters of 3 taps each. A commutator hands each accepted sample to the next branch. Each branch therefore shifts its own short delay line at one twenty-fifth of the input rate. As each sample arrives, the datapath evaluates only that branch's three taps and adds the result into a wide accumulator. When the twenty-fifth sample of a group has been accepted, the accumulator holds one output sample. It is rounded, saturated to 16 bits and presented with a one-cycle valid pulse.

Input samples may arrive with gaps. Only cycles with the input valid high count toward a group. A bypass input replaces the filtered result with the last raw sample of the group, for streams that are already band-limited. The block sits between a high-rate sample source and a slower processing chain in the same clock domain.

Top module: `pfd_decim25`

## Requirements
- R1: While `rst_ni` is low, `valid_o` is 0 and `data_o` is 0. Reset also clears every branch delay line, the accumulator and the group position, so the next output needs 25 fresh accepted inputs, and samples from before the reset contribute zero.
- R2: Exactly one output is produced for each 25 accepted inputs. `valid_o` is high for one cycle, in the cycle that follows the clock edge that accepts the 25th input of a group. Cycles with `valid_i` low do not advance the group.
- R3: With bypass low, the output is y = sum over i = 0..74 of h[i]*x[n-i], where x[n] is the 25th input of the group, x[n-i] is the i-th accepted input before it, and h[i] is entry i of the `COEFS` parameter. The branch that receives the input lying k places before the group's last input uses h[k], h[k+25] and h[k+50].
- R4: Coefficients are fixed point with 17 fractional bits. y is rounded to an integer by adding 2^16 and then shifting right arithmetically by 17 (round half up).
- R5: A rounded result above 32767 is output as 32767. A rounded result below -32768 is output as -32768.
- R6: If `bypass_i` is high on the cycle that accepts the 25th input of a group, the output is that input sample, unchanged.
- R7: `data_o` keeps its value in every cycle in which `valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample is present this cycle |
| data_i | input | 16 | Input sample, two's complement |
| bypass_i | input | 1 | Emit the raw last sample of the group instead of the filtered result |
| valid_o | output | 1 | One-cycle strobe marking a new output sample |
| data_o | output | 16 | Output sample, two's complement |

## Verification
A commutator that slips by one position moves every later output onto the wrong coefficients. The first output after the slip then differs from the reference convolution, or the valid pulse arrives one input early or late. A single impulse after reset places its amplitude on h[24], h[49] and h[74] in three successive outputs, so a wrong branch mapping shows up within 75 inputs. A stale delay line or an accumulator that is not cleared corrupts the next output at the latest. Gapped random stimulus, full-scale runs and a reset in the middle of a group expose counting errors, saturation errors and residual state within one group of 25.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int DATA_W = 16;
  localparam int COEF_W = 18;
  localparam int FACTOR = 25;
  localparam int TAPS   = 3;
  localparam int FRAC_W = 17;
  localparam int NCOEF  = FACTOR * TAPS;

  typedef logic signed [COEF_W-1:0] coef_t;
  typedef coef_t coef_arr_t [NCOEF];

  // triangular placeholder response; real designs override COEFS
  function automatic coef_arr_t default_coefs();
    coef_arr_t c;
    for (int i = 0; i < NCOEF; i++) begin
      c[i] = coef_t'(((i < NCOEF / 2) ? (i + 1) : (NCOEF - i)) * 90);
    end
    return c;
  endfunction
endpackage

// File: rtl/pfd_commutator.sv
module pfd_commutator #(
  parameter int FACTOR = pfd_pkg::FACTOR,
  localparam int IW = $clog2(FACTOR)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [IW-1:0] sel_o,
  output logic          last_o
);
  // sel_o = distance of the current sample from the group's last sample
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= IW'(FACTOR - 1);
    else if (adv_i) idx_q <= (idx_q == '0) ? IW'(FACTOR - 1) : idx_q - 1'b1;
  end

  assign sel_o  = idx_q;
  assign last_o = (idx_q == '0);

  p_idx_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q < IW'(FACTOR));
  p_idx_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(idx_q));
endmodule

// File: rtl/pfd_branch_bank.sv
module pfd_branch_bank #(
  parameter int DATA_W = pfd_pkg::DATA_W,
  parameter int FACTOR = pfd_pkg::FACTOR,
  parameter int TAPS   = pfd_pkg::TAPS,
  localparam int IW = $clog2(FACTOR)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_i,
  input  logic [IW-1:0]                sel_i,
  input  logic [DATA_W-1:0]            din_i,
  output logic [TAPS-1:0][DATA_W-1:0]  taps_o
);
  logic [TAPS-1:1][DATA_W-1:0] lines [FACTOR];

  for (genvar k = 0; k < FACTOR; k++) begin : g_br
    logic [TAPS-1:1][DATA_W-1:0] line_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        line_q <= '0;
      end else if (wr_i && sel_i == IW'(k)) begin
        line_q[1] <= din_i;
        for (int j = 2; j < TAPS; j++) line_q[j] <= line_q[j-1];
      end
    end
    assign lines[k] = line_q;
  end

  // tap 0 is the arriving sample, older taps come from the selected branch
  always_comb begin
    taps_o = '0;
    taps_o[0] = din_i;
    for (int k = 0; k < FACTOR; k++) begin
      if (sel_i == IW'(k)) taps_o[TAPS-1:1] = lines[k];
    end
  end
endmodule

// File: rtl/pfd_mac.sv
module pfd_mac #(
  parameter int DATA_W = pfd_pkg::DATA_W,
  parameter int COEF_W = pfd_pkg::COEF_W,
  parameter int FACTOR = pfd_pkg::FACTOR,
  parameter int TAPS   = pfd_pkg::TAPS,
  parameter int ACC_W  = DATA_W + COEF_W + $clog2(FACTOR * TAPS),
  parameter pfd_pkg::coef_arr_t COEFS = pfd_pkg::default_coefs(),
  localparam int IW = $clog2(FACTOR),
  localparam int PW = DATA_W + COEF_W
) (
  input  logic [IW-1:0]               sel_i,
  input  logic [TAPS-1:0][DATA_W-1:0] taps_i,
  output logic signed [ACC_W-1:0]     partial_o
);
  logic signed [COEF_W-1:0] coef;
  logic signed [PW-1:0]     prod;

  always_comb begin
    partial_o = '0;
    coef = '0;
    prod = '0;
    for (int j = 0; j < TAPS; j++) begin
      coef = '0;
      for (int k = 0; k < FACTOR; k++) begin
        if (sel_i == IW'(k)) coef = COEFS[k + FACTOR * j];
      end
      prod = PW'(signed'(taps_i[j])) * PW'(coef);
      partial_o = partial_o + {{(ACC_W - PW){prod[PW-1]}}, prod};
    end
  end
endmodule

// File: rtl/pfd_accum.sv
module pfd_accum #(
  parameter int DATA_W = pfd_pkg::DATA_W,
  parameter int ACC_W  = 41,
  parameter int FRAC_W = pfd_pkg::FRAC_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    add_i,
  input  logic                    last_i,
  input  logic                    bypass_i,
  input  logic signed [ACC_W-1:0] partial_i,
  input  logic [DATA_W-1:0]       raw_i,
  output logic                    valid_o,
  output logic [DATA_W-1:0]       data_o
);
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) << (FRAC_W - 1);
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] MINV = -(ACC_W'(1) << (DATA_W - 1));

  logic signed [ACC_W-1:0] acc_q, total, rnd;
  logic [DATA_W-1:0] sat;

  assign total = acc_q + partial_i;
  assign rnd   = (total + HALF) >>> FRAC_W;

  always_comb begin
    if (rnd > MAXV)      sat = MAXV[DATA_W-1:0];
    else if (rnd < MINV) sat = MINV[DATA_W-1:0];
    else                 sat = rnd[DATA_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= 1'b0;
      if (add_i) begin
        if (last_i) begin
          acc_q   <= '0;
          valid_o <= 1'b1;
          data_o  <= bypass_i ? raw_i : sat;
        end else begin
          acc_q <= total;
        end
      end
    end
  end

  p_valid_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  p_data_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> data_o == $past(data_o));
endmodule

// File: rtl/pfd_decim25.sv
module pfd_decim25 #(
  parameter int DATA_W = pfd_pkg::DATA_W,
  parameter int COEF_W = pfd_pkg::COEF_W,
  parameter int FACTOR = pfd_pkg::FACTOR,
  parameter int TAPS   = pfd_pkg::TAPS,
  parameter int FRAC_W = pfd_pkg::FRAC_W,
  parameter pfd_pkg::coef_arr_t COEFS = pfd_pkg::default_coefs()
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              bypass_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int IW    = $clog2(FACTOR);
  localparam int ACC_W = DATA_W + COEF_W + $clog2(FACTOR * TAPS);

  logic [IW-1:0]               sel;
  logic                        last;
  logic [TAPS-1:0][DATA_W-1:0] taps;
  logic signed [ACC_W-1:0]     partial;

  pfd_commutator #(.FACTOR(FACTOR)) u_comm (
    .clk_i, .rst_ni, .adv_i(valid_i), .sel_o(sel), .last_o(last)
  );

  pfd_branch_bank #(.DATA_W(DATA_W), .FACTOR(FACTOR), .TAPS(TAPS)) u_bank (
    .clk_i, .rst_ni, .wr_i(valid_i), .sel_i(sel), .din_i(data_i), .taps_o(taps)
  );

  pfd_mac #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .FACTOR(FACTOR), .TAPS(TAPS),
    .ACC_W(ACC_W), .COEFS(COEFS)
  ) u_mac (
    .sel_i(sel), .taps_i(taps), .partial_o(partial)
  );

  pfd_accum #(.DATA_W(DATA_W), .ACC_W(ACC_W), .FRAC_W(FRAC_W)) u_acc (
    .clk_i, .rst_ni, .add_i(valid_i), .last_i(last), .bypass_i,
    .partial_i(partial), .raw_i(data_i), .valid_o, .data_o
  );

  p_valid_after_last_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && last) |=> valid_o);
  p_no_early_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && last) |=> !valid_o);
  p_bypass_raw_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && last && bypass_i) |=> data_o == $past(data_i));
endmodule

// File: tb/tb_pfd_decim25.sv
`timescale 1ns/1ps
module tb_pfd_decim25;
  import pfd_pkg::*;

  function automatic coef_arr_t tb_coefs();
    coef_arr_t c;
    for (int i = 0; i < NCOEF; i++) c[i] = coef_t'(((i * 37 + 11) % 101) * 900 - 20000);
    return c;
  endfunction
  localparam coef_arr_t TB_COEFS = tb_coefs();

  logic clk = 1'b0, rst_ni = 1'b0, valid_i = 1'b0, bypass_i = 1'b0;
  logic [15:0] data_i = '0;
  logic valid_o;
  logic [15:0] data_o;

  pfd_decim25 #(.COEFS(TB_COEFS)) dut (
    .clk_i(clk), .rst_ni, .valid_i, .data_i, .bypass_i, .valid_o, .data_o
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  longint hist [NCOEF];
  int cnt = 0;
  bit pend = 0;
  longint exp_val = 0;
  string exp_tag = "R3";
  longint last_out = 0;
  bit done = 0;

  function automatic void clear_model();
    for (int i = 0; i < NCOEF; i++) hist[i] = 0;
    cnt = 0; pend = 0; last_out = 0;
  endfunction

  function automatic void check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endfunction

  // reference convolution with rounding and saturation
  function automatic longint filt(output string tag);
    longint acc = 0, rnd;
    for (int i = 0; i < NCOEF; i++) acc += longint'(TB_COEFS[i]) * hist[i];
    rnd = (acc + (longint'(1) <<< (FRAC_W - 1))) >>> FRAC_W;
    tag = ((acc & ((longint'(1) <<< FRAC_W) - 1)) != 0) ? "R4" : "R3";
    if (rnd > 32767) begin rnd = 32767; tag = "R5"; end
    if (rnd < -32768) begin rnd = -32768; tag = "R5"; end
    return rnd;
  endfunction

  task automatic check_out();
    longint act = longint'($signed(data_o));
    if (pend) begin
      check("R2 valid", longint'(valid_o), 1);
      check(exp_tag, act, exp_val);
      last_out = act;
      pend = 0;
    end else begin
      if (valid_o) check("R2 spurious valid", 1, 0);
      else check("R7 hold", act, last_out);
    end
  endtask

  task automatic step(bit v, logic [15:0] d, bit byp);
    @(negedge clk);
    check_out();
    valid_i = v; data_i = d; bypass_i = byp;
    if (v) begin
      for (int i = NCOEF - 1; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = longint'($signed(d));
      cnt++;
      if (cnt == FACTOR) begin
        cnt = 0; pend = 1;
        if (byp) begin exp_val = hist[0]; exp_tag = "R6"; end
        else exp_val = filt(exp_tag);
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    check_out();
    valid_i = 0;
    rst_ni = 0;
    clear_model();
    repeat (2) @(negedge clk);
    check("R1 reset valid", longint'(valid_o), 0);
    check("R1 reset data", longint'($signed(data_o)), 0);
    rst_ni = 1;
  endtask

  function automatic logic [15:0] rnd_small();
    return 16'(int'($urandom_range(4095)) - 2048);
  endfunction

  initial begin
    void'($urandom(32'd1234));
    clear_model();
    do_reset();
    // R3 impulse walks through h[24], h[49], h[74]
    step(1, 16'd1000, 0);
    for (int i = 0; i < 3 * FACTOR - 1; i++) step(1, 16'd0, 0);
    // random with gaps
    for (int i = 0; i < 1500; i++) step($urandom_range(9) < 7, rnd_small(), 0);
    // R5 saturation both ways
    for (int i = 0; i < 3 * FACTOR; i++) step(1, 16'h7fff, 0);
    for (int i = 0; i < 3 * FACTOR; i++) step(1, 16'h8000, 0);
    // R6 bypass, full-range data
    for (int i = 0; i < 10 * FACTOR; i++) step(1, 16'($urandom), 1);
    // R1 reset mid-group: next output needs 25 fresh inputs
    for (int i = 0; i < 10; i++) step(1, rnd_small(), 0);
    do_reset();
    for (int i = 0; i < FACTOR; i++) step(1, rnd_small(), 0);
    // mixed bypass per group with gaps
    for (int g = 0; g < 40; g++) begin
      bit byp = $urandom_range(1) == 1;
      int n = 0;
      while (n < FACTOR) begin
        bit v = $urandom_range(3) != 0;
        step(v, 16'($urandom), byp);
        if (v) n++;
      end
    end
    for (int i = 0; i < 4; i++) step(0, 16'd0, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule